// File: doc/BRIEF.md
# UART Hold-and-Load Boot Controller

This block lets a host computer take charge of a soft processor over the same serial link the processor uses for its own console output. Every received byte goes to the processor and to this controller at once. The transmit side is shared: a multiplexer selects either the processor's byte stream or the controller's reply bytes, and only the controller drives that select.

After reset the processor is held inactive, and transmit stays with the processor. The host opens a debug frame with a sync byte, which hands transmit to the controller. Frames then write the program image into memory one word at a time and set the start address. A final start frame produces a one-cycle start pulse that releases the processor, and transmit returns to it. The block works on byte-valid strobes. Serialization is done by a separate line interface.

Top module: `boot_uart_ctl`

## Requirements
- R1: Every received byte appears on the processor receive outputs in the same cycle, with the same value, whether or not a frame is in progress.
- R2: After reset `cpu_hold` is 1, `tx_owner` is 0, `start_addr` is 0, and `start_pulse` and `mem_we` are 0. While `tx_owner` is 0, `tx_valid`/`tx_data` carry `cpu_tx_valid`/`cpu_tx_data`.
- R3: While no frame is open, any received byte other than 0xA5 has no effect. `tx_owner` stays 0 and no reply byte is sent.
- R4: The sync byte 0xA5 sets `tx_owner` to 1 from the next cycle. From then on the processor's transmit bytes are not forwarded.
- R5: Opcode 0x01 is followed by a 4-byte address and then a 4-byte data word, each least significant byte first. While the processor is held, `mem_we` pulses for one cycle, starting one cycle after the last byte, with that address and data. In the same cycle the reply byte 0x06 is sent.
- R6: Opcode 0x02 is followed by a 4-byte address, least significant byte first. It loads `start_addr` one cycle after the last byte and replies 0x06 in that cycle.
- R7: Opcode 0x03 raises `start_pulse` for exactly one cycle, one cycle after the opcode byte. In that cycle `cpu_hold` falls and 0x06 is sent. `cpu_hold` then stays 0, and `tx_owner` returns to 0 in the following cycle.
- R8: Any other opcode byte gets the reply 0x15, and the controller goes back to waiting for 0xA5. The next byte is not read as an opcode.
- R9: A write frame received while the processor is running produces no memory write and gets the reply 0x15. `tx_owner` returns to 0 the cycle after any reply sent while the processor runs.
- R10: An open frame is discarded after 65535 consecutive cycles with no received byte. With a gap of 65534 cycles the frame is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| cpu_rx_valid | output | 1 | Received byte strobe forwarded to processor |
| cpu_rx_data | output | 8 | Received byte forwarded to processor |
| cpu_tx_valid | input | 1 | Processor transmit strobe |
| cpu_tx_data | input | 8 | Processor transmit byte |
| tx_valid | output | 1 | Muxed transmit strobe |
| tx_data | output | 8 | Muxed transmit byte |
| tx_owner | output | 1 | 1 when the controller owns transmit |
| cpu_hold | output | 1 | Holds the processor inactive |
| start_addr | output | 32 | Processor start address |
| start_pulse | output | 1 | One-cycle release strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |

## Verification
The receive forwarding and the transmit mux are combinational, so the bench checks them in the same cycle it drives them. Every frame result (write strobe, start address, start pulse, reply byte) is registered and appears one cycle after the byte that ends the frame. The bench drives each byte on a falling edge and checks on the next falling edge, which lies just after the capturing rising edge. The return of transmit to the processor comes one cycle later, and the bench checks it on the falling edge after that. For the timeout, the bench counts the exact number of empty rising edges between bytes and tests one gap just under the limit and one gap at the limit.

// File: rtl/boot_uart_ctl.sv
module boot_uart_ctl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TIMEOUT = 65535,
  parameter logic [7:0] SYNC = 8'hA5,
  parameter logic [7:0] ACK = 8'h06,
  parameter logic [7:0] NAK = 8'h15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          cpu_rx_valid,
  output logic [7:0]    cpu_rx_data,
  input  logic          cpu_tx_valid,
  input  logic [7:0]    cpu_tx_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_owner,
  output logic          cpu_hold,
  output logic [AW-1:0] start_addr,
  output logic          start_pulse,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int SW  = AW + DW;
  localparam int NWR = SW / 8;
  localparam int NSA = AW / 8;
  localparam int CW  = $clog2(NWR + 1);
  localparam int GW  = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_HUNT, S_OPC, S_PAY} st_t;

  st_t           st;
  logic          is_wr;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;
  logic [SW-1:0] sh;
  logic [SW-1:0] sh_nxt;
  logic          rep_v;
  logic [7:0]    rep_b;
  logic          last;

  assign cpu_rx_valid = rx_valid;
  assign cpu_rx_data  = rx_data;
  assign tx_valid     = tx_owner ? rep_v : cpu_tx_valid;
  assign tx_data      = tx_owner ? rep_b : cpu_tx_data;
  assign sh_nxt       = {rx_data, sh[SW-1:8]};
  assign last         = (cnt == CW'(is_wr ? NWR - 1 : NSA - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_HUNT;
      is_wr       <= 1'b0;
      cnt         <= '0;
      gap         <= '0;
      sh          <= '0;
      rep_v       <= 1'b0;
      rep_b       <= '0;
      tx_owner    <= 1'b0;
      cpu_hold    <= 1'b1;
      start_addr  <= '0;
      start_pulse <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      mem_we      <= 1'b0;
      start_pulse <= 1'b0;
      rep_v       <= 1'b0;
      if (rep_v && !cpu_hold) tx_owner <= 1'b0;
      if (rx_valid) gap <= '0;

      case (st)
        S_HUNT: if (rx_valid && rx_data == SYNC) begin
          st       <= S_OPC;
          tx_owner <= 1'b1;
        end
        S_OPC: if (rx_valid) begin
          rep_v <= 1'b1;
          cnt   <= '0;
          unique case (rx_data)
            8'h01: begin st <= S_PAY; is_wr <= 1'b1; rep_v <= 1'b0; end
            8'h02: begin st <= S_PAY; is_wr <= 1'b0; rep_v <= 1'b0; end
            8'h03: begin
              st          <= S_HUNT;
              start_pulse <= 1'b1;
              cpu_hold    <= 1'b0;
              rep_b       <= ACK;
            end
            default: begin st <= S_HUNT; rep_b <= NAK; end
          endcase
        end
        S_PAY: if (rx_valid) begin
          sh  <= sh_nxt;
          cnt <= cnt + 1'b1;
          if (last) begin
            st    <= S_HUNT;
            rep_v <= 1'b1;
            rep_b <= ACK;
            if (is_wr) begin
              if (cpu_hold) begin
                mem_we    <= 1'b1;
                mem_addr  <= sh_nxt[AW-1:0];
                mem_wdata <= sh_nxt[SW-1:AW];
              end else begin
                rep_b <= NAK;
              end
            end else begin
              start_addr <= sh_nxt[SW-1 -: AW];
            end
          end
        end
        default: st <= S_HUNT;
      endcase

      if (st != S_HUNT && !rx_valid) begin
        if (gap == GW'(TIMEOUT - 1)) begin
          st  <= S_HUNT;
          gap <= '0;
          if (!cpu_hold) tx_owner <= 1'b0;
        end else begin
          gap <= gap + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/boot_uart_ctl_chk.sv
module boot_uart_ctl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_owner,
  input logic          cpu_hold,
  input logic          start_pulse,
  input logic          mem_we
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r7_hold_falls_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> start_pulse);
  a_r7_pulse_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !cpu_hold && tx_valid && tx_data == 8'h06);
  a_r7_hold_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |=> !cpu_hold);
  a_r7_tx_handback: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !tx_owner);
  a_r9_write_only_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cpu_hold);
  a_r5_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> tx_owner && tx_valid && tx_data == 8'h06);
  a_r5_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

bind boot_uart_ctl boot_uart_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_owner(tx_owner), .cpu_hold(cpu_hold), .start_pulse(start_pulse),
  .mem_we(mem_we)
);

// File: tb/boot_uart_ctl_test.sv
module boot_uart_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        cpu_rx_valid;
  logic [7:0]  cpu_rx_data;
  logic        cpu_tx_valid = 1'b1;
  logic [7:0]  cpu_tx_data = 8'h41;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_owner;
  logic        cpu_hold;
  logic [31:0] start_addr;
  logic        start_pulse;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_uart_ctl uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send32(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send(w[8*i +: 8]);
  endtask

  task automatic t_reset;
    chk(cpu_hold == 1'b1, "R2 hold", 32'(cpu_hold), 1);
    chk(tx_owner == 1'b0, "R2 owner", 32'(tx_owner), 0);
    chk(start_addr == 32'h0, "R2 start_addr", start_addr, 0);
    chk(!start_pulse && !mem_we, "R2 strobes", {start_pulse, mem_we}, 0);
    chk(tx_valid && tx_data == 8'h41, "R2 tx follows cpu", {tx_valid, tx_data}, 32'h141);
    rx_valid = 1'b1; rx_data = 8'h33; #1;
    chk(cpu_rx_valid && cpu_rx_data == 8'h33, "R1 rx forward", {cpu_rx_valid, cpu_rx_data}, 32'h133);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_ignore;
    logic [7:0] junk [3] = '{8'h00, 8'h5A, 8'h03};
    for (int i = 0; i < 3; i++) begin
      send(junk[i]);
      chk(!tx_owner && tx_data == 8'h41, "R3 ignored byte", {tx_owner, tx_data}, 32'h041);
      chk(!start_pulse && cpu_hold, "R3 no start", {start_pulse, cpu_hold}, 1);
    end
  endtask

  task automatic t_write;
    send(8'hA5);
    chk(tx_owner == 1'b1, "R4 owner", 32'(tx_owner), 1);
    chk(tx_valid == 1'b0, "R4 cpu tx blocked", 32'(tx_valid), 0);
    rx_valid = 1'b1; rx_data = 8'h01; #1;
    chk(cpu_rx_valid && cpu_rx_data == 8'h01, "R1 rx forward in frame", {cpu_rx_valid, cpu_rx_data}, 32'h101);
    @(negedge clk); rx_valid = 1'b0;
    send32(32'h0000_0100);
    send32(32'hDEAD_BEEF);
    chk(mem_we == 1'b1, "R5 we", 32'(mem_we), 1);
    chk(mem_addr == 32'h100, "R5 addr", mem_addr, 32'h100);
    chk(mem_wdata == 32'hDEADBEEF, "R5 data", mem_wdata, 32'hDEADBEEF);
    chk(tx_valid && tx_data == 8'h06, "R5 ack", {tx_valid, tx_data}, 32'h106);
    @(negedge clk);
    chk(!mem_we && tx_owner, "R5 one pulse, owner kept", {mem_we, tx_owner}, 1);
  endtask

  task automatic t_badop;
    send(8'hA5);
    send(8'h07);
    chk(tx_valid && tx_data == 8'h15, "R8 nak", {tx_valid, tx_data}, 32'h115);
    send(8'h03);
    chk(!start_pulse && cpu_hold, "R8 back to hunt", {start_pulse, cpu_hold}, 1);
  endtask

  task automatic t_timeout;
    send(8'hA5); send(8'h02); send(8'h78);
    repeat (65534) @(negedge clk);
    send(8'h56); send(8'h34); send(8'h12);
    chk(start_addr == 32'h1234_5678, "R10 gap below limit / R6", start_addr, 32'h12345678);
    chk(tx_valid && tx_data == 8'h06, "R6 ack", {tx_valid, tx_data}, 32'h106);
    send(8'hA5); send(8'h02); send(8'h11);
    repeat (65535) @(negedge clk);
    send(8'h22); send(8'h33); send(8'h44);
    chk(start_addr == 32'h1234_5678, "R10 frame discarded", start_addr, 32'h12345678);
    chk(tx_valid == 1'b0, "R10 no reply", 32'(tx_valid), 0);
  endtask

  task automatic t_start;
    send(8'hA5); send(8'h02); send32(32'h8000_0000);
    chk(start_addr == 32'h8000_0000, "R6 start_addr", start_addr, 32'h80000000);
    send(8'hA5); send(8'h03);
    chk(start_pulse == 1'b1, "R7 pulse", 32'(start_pulse), 1);
    chk(cpu_hold == 1'b0, "R7 release", 32'(cpu_hold), 0);
    chk(tx_valid && tx_data == 8'h06, "R7 ack", {tx_valid, tx_data}, 32'h106);
    @(negedge clk);
    chk(!start_pulse && !cpu_hold, "R7 single pulse, hold low", {start_pulse, cpu_hold}, 0);
    chk(!tx_owner && tx_data == 8'h41, "R7 tx back to cpu", {tx_owner, tx_data}, 32'h041);
  endtask

  task automatic t_write_running;
    send(8'hA5); send(8'h01);
    send32(32'h0000_0200);
    send32(32'h1111_2222);
    chk(mem_we == 1'b0, "R9 no write", 32'(mem_we), 0);
    chk(tx_valid && tx_data == 8'h15, "R9 nak", {tx_valid, tx_data}, 32'h115);
    @(negedge clk);
    chk(!tx_owner, "R9 owner returned", 32'(tx_owner), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_write();
    t_badop();
    t_timeout();
    t_start();
    t_write_running();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule